// File: doc/BRIEF.md
# Interrupt Control and System Register Unit

This unit sits in the memory-access stage of a small in-order pipeline. It keeps four system registers: a control word with an enable bit and a saved-enable bit, the interrupt handler's entry address, the saved return address, and the number of the source that caused the last interrupt. It also decodes the three system instructions that touch these registers: a system read, a system write, and a return-from-interrupt. The instruction arrives as a full 32-bit word, together with the value of its source register.

Every cycle the unit merges the device request lines through a fixed-priority encoder. It takes an interrupt when interrupts are enabled, at least one request is active, and the stage slot holds a real instruction rather than a bubble. On a take, it pulses a take flag and redirects fetch to the handler address. At the same clock edge it saves the next-PC value it was given, the winning source number, and the enable state.

Reads and writes of the system registers both happen in this one stage. The pipeline therefore never has to forward system-register values.

Top module: `irq_sysreg_unit`

## Requirements
- R1: After synchronous reset the control word, return address and cause register read as zero, and the handler address reads as parameter `HANDLER_RESET`.
- R2: A system read (instruction bits [31:28]=4'hF, [27:24]=4'h2, [23:20]=destination GPR, [19:16]=system register number, [15:0]=0) raises `sr_read_valid` in the same cycle. It echoes the destination on `sr_read_dst` and returns the register value on `sr_read_data`. The numbers are 0 = control, 1 = handler address, 2 = return address and 3 = cause. The control word reads as {30'b0, saved_enable, enable}. Any number above 3 reads as zero.
- R3: A system write ([31:28]=4'hF, [27:24]=4'h3, [23:20]=system register number, [19:16]=source GPR, [15:0]=0) stores `src_val` into the selected register at the next edge. Only bits [1:0] are kept for the control word, and only the low 4 bits for the cause. Writes to numbers above 3 change nothing.
- R4: `irq_id` is the priority-encoded request: source bit 0 gives 1, else bit 1 gives 2, else bit 2 gives 3, and no request gives 4'hF.
- R5: `irq_take` is high in the cycle where enable is 1, some request is active and `slot_bubble` is 0. In that cycle `redirect_valid` is high and `redirect_pc` equals the handler address.
- R6: On a take, the return address gets `next_pc`, the cause gets `irq_id`, and {saved_enable, enable} gets {enable, 0}.
- R7: A return-from-interrupt ([31:28]=4'hF, [27:24]=4'h1, [23:0]=0) raises `redirect_valid` with `redirect_pc` equal to the return address. It loads enable from saved_enable and leaves saved_enable unchanged.
- R8: While `slot_bubble` is 1, no interrupt is taken and no register changes because of a request.
- R9: If a system write to the control word meets a take in the same cycle, the take decision uses the enable bit from before the write. The written enable bit then becomes saved_enable, and enable ends at 0.
- R10: If a return-from-interrupt meets a take in the same cycle, the return executes first. The redirect goes to the handler, the saved return address is the old return address, and saved_enable gets the enable value the return produced.
- R11: A word whose primary opcode is not 4'hF, whose secondary opcode is not 1 to 3, or whose zero field is nonzero, has no effect. So does any word presented while `inst_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_SRC | Device requests, bit 0 highest priority |
| inst_valid | input | 1 | Instruction word in this stage is real |
| inst | input | 32 | Instruction word in this stage |
| src_val | input | XLEN | Source GPR value for a system write |
| next_pc | input | XLEN | Committed next-instruction address |
| slot_bubble | input | 1 | Slot holds a pipeline bubble |
| irq_id | output | ID_W | Priority-encoded pending source number |
| irq_take | output | 1 | Interrupt taken this cycle |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| sr_read_valid | output | 1 | System read in this cycle |
| sr_read_dst | output | 4 | Destination GPR of the system read |
| sr_read_data | output | XLEN | System register read value |

## Verification
A wrong enable or saved-enable bit appears at the ports in the first cycle it matters. `irq_take` either fires when it should stay quiet or stays low when it should fire. A later return-from-interrupt then restores the wrong enable. A bad return address or cause value stays hidden until it is read back or a return uses it, so the bench reads every register right after each take and each conflict case. The sweep covers every request pattern against both enable values and both bubble states. Every same-cycle ordering case is checked one cycle after the edge where it occurs.

// File: rtl/irqsys_pkg.sv
package irqsys_pkg;

    localparam logic [3:0] OP_SYSTEM  = 4'hF;
    localparam logic [3:0] SUB_INTRET = 4'h1;
    localparam logic [3:0] SUB_SREAD  = 4'h2;
    localparam logic [3:0] SUB_SWRITE = 4'h3;

    typedef enum logic [3:0] {
        SR_CTL     = 4'd0,
        SR_HANDLER = 4'd1,
        SR_RETADDR = 4'd2,
        SR_CAUSE   = 4'd3
    } sreg_e;

    typedef struct packed {
        logic       intret;
        logic       sread;
        logic       swrite;
        logic [3:0] gpr;
        logic [3:0] sreg;
    } sysop_t;

    function automatic logic is_sreg(input logic [3:0] n, input sreg_e which);
        return n == which;
    endfunction

endpackage

// File: rtl/sysinst_decode.sv
module sysinst_decode
    import irqsys_pkg::*;
(
    input  logic        inst_valid,
    input  logic [31:0] inst,
    output sysop_t      op
);
    logic       sys_hit;
    logic [3:0] sub;
    logic       low16_zero;

    assign sys_hit    = inst_valid && (inst[31:28] == OP_SYSTEM);
    assign sub        = inst[27:24];
    assign low16_zero = (inst[15:0] == 16'h0000);

    always_comb begin
        op        = '0;
        op.intret = sys_hit && (sub == SUB_INTRET) && (inst[23:0] == 24'h0);
        op.sread  = sys_hit && (sub == SUB_SREAD)  && low16_zero;
        op.swrite = sys_hit && (sub == SUB_SWRITE) && low16_zero;
        if (sub == SUB_SREAD) begin
            op.gpr  = inst[23:20];
            op.sreg = inst[19:16];
        end else begin
            op.sreg = inst[23:20];
            op.gpr  = inst[19:16];
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 3,
    parameter int ID_W  = 4
) (
    input  logic [N_SRC-1:0] req,
    output logic             any,
    output logic [ID_W-1:0]  id
);
    localparam logic [ID_W-1:0] ID_NONE = '1;

    logic [N_SRC:0]       below;
    logic [N_SRC-1:0]     hit;
    logic [ID_W-1:0]      part [N_SRC+1];

    assign below[0] = 1'b0;
    assign part[0]  = '0;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chain
        assign below[g+1] = below[g] | req[g];
        assign hit[g]     = req[g] & ~below[g];
        assign part[g+1]  = part[g] | (hit[g] ? ID_W'(g + 1) : '0);
    end

    assign any = below[N_SRC];
    assign id  = any ? part[N_SRC] : ID_NONE;

    initial begin
        if (N_SRC + 1 >= (1 << ID_W)) $error("source count does not fit ID_W");
    end
endmodule

// File: rtl/irq_sysregs.sv
module irq_sysregs
    import irqsys_pkg::*;
#(
    parameter int               XLEN          = 32,
    parameter int               ID_W          = 4,
    parameter logic [XLEN-1:0]  HANDLER_RESET = 32'h0000_0010
) (
    input  logic            clk,
    input  logic            rst,
    input  sysop_t          op,
    input  logic [XLEN-1:0] wval,
    input  logic            take,
    input  logic [ID_W-1:0] take_id,
    input  logic [XLEN-1:0] take_ret,
    output logic            ie,
    output logic [XLEN-1:0] handler,
    output logic [XLEN-1:0] retaddr,
    output logic [XLEN-1:0] rdata
);
    logic            ie_q, oie_q, ie_n, oie_n;
    logic [XLEN-1:0] handler_q, handler_n, ret_q, ret_n;
    logic [ID_W-1:0] cause_q, cause_n;
    logic            wr_ctl, wr_hnd, wr_ret, wr_cause;

    assign wr_ctl   = op.swrite && is_sreg(op.sreg, SR_CTL);
    assign wr_hnd   = op.swrite && is_sreg(op.sreg, SR_HANDLER);
    assign wr_ret   = op.swrite && is_sreg(op.sreg, SR_RETADDR);
    assign wr_cause = op.swrite && is_sreg(op.sreg, SR_CAUSE);

    // Instruction effect first, interrupt update applied on top.
    always_comb begin
        ie_n  = ie_q;
        oie_n = oie_q;
        if (op.intret) ie_n = oie_q;
        if (wr_ctl) begin
            ie_n  = wval[0];
            oie_n = wval[1];
        end
        if (take) begin
            oie_n = ie_n;
            ie_n  = 1'b0;
        end
        handler_n = wr_hnd ? wval : handler_q;
        ret_n     = take ? take_ret : (wr_ret ? wval : ret_q);
        cause_n   = take ? take_id  : (wr_cause ? wval[ID_W-1:0] : cause_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q      <= 1'b0;
            oie_q     <= 1'b0;
            handler_q <= HANDLER_RESET;
            ret_q     <= '0;
            cause_q   <= '0;
        end else begin
            ie_q      <= ie_n;
            oie_q     <= oie_n;
            handler_q <= handler_n;
            ret_q     <= ret_n;
            cause_q   <= cause_n;
        end
    end

    always_comb begin
        rdata = '0;
        case (op.sreg)
            SR_CTL:     rdata = {{(XLEN-2){1'b0}}, oie_q, ie_q};
            SR_HANDLER: rdata = handler_q;
            SR_RETADDR: rdata = ret_q;
            SR_CAUSE:   rdata = {{(XLEN-ID_W){1'b0}}, cause_q};
            default:    rdata = '0;
        endcase
    end

    assign ie      = ie_q;
    assign handler = handler_q;
    assign retaddr = ret_q;

    AST_TAKE_STACKS_IE: assert property (@(posedge clk) disable iff (rst)
        (take && !op.intret && !wr_ctl) |=> (!ie_q && oie_q == $past(ie_q))); // R6
    AST_INTRET_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (op.intret && !take) |=> (ie_q == $past(oie_q) && oie_q == $past(oie_q))); // R7
    AST_CONFLICT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (take && wr_ctl) |=> (!ie_q && oie_q == $past(wval[0]))); // R9
    AST_HANDLER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_hnd |=> $stable(handler_q)); // R3
    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op.sread && op.sreg > 4'd3) |-> (rdata == '0)); // R2
endmodule

// File: rtl/irq_sysreg_unit.sv
module irq_sysreg_unit
    import irqsys_pkg::*;
#(
    parameter int               XLEN          = 32,
    parameter int               N_SRC         = 3,
    parameter int               ID_W          = 4,
    parameter logic [XLEN-1:0]  HANDLER_RESET = 32'h0000_0010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_src,
    input  logic             inst_valid,
    input  logic [31:0]      inst,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  next_pc,
    input  logic             slot_bubble,
    output logic [ID_W-1:0]  irq_id,
    output logic             irq_take,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic             sr_read_valid,
    output logic [3:0]       sr_read_dst,
    output logic [XLEN-1:0]  sr_read_data
);
    sysop_t          op;
    logic            any_req, ie;
    logic [XLEN-1:0] handler, retaddr, take_ret;

    sysinst_decode u_dec (
        .inst_valid (inst_valid),
        .inst       (inst),
        .op         (op)
    );

    irq_prio_enc #(.N_SRC(N_SRC), .ID_W(ID_W)) u_prio (
        .req (irq_src),
        .any (any_req),
        .id  (irq_id)
    );

    assign irq_take = !rst && ie && any_req && !slot_bubble;
    assign take_ret = op.intret ? retaddr : next_pc;

    irq_sysregs #(.XLEN(XLEN), .ID_W(ID_W), .HANDLER_RESET(HANDLER_RESET)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wval     (src_val),
        .take     (irq_take),
        .take_id  (irq_id),
        .take_ret (take_ret),
        .ie       (ie),
        .handler  (handler),
        .retaddr  (retaddr),
        .rdata    (sr_read_data)
    );

    assign redirect_valid = irq_take || op.intret;
    assign redirect_pc    = irq_take ? handler : retaddr;
    assign sr_read_valid  = op.sread;
    assign sr_read_dst    = op.gpr;

    AST_TAKE_SAVES_RET: assert property (@(posedge clk) disable iff (rst)
        (irq_take && !op.intret) |=> (retaddr == $past(next_pc))); // R6
    AST_BUBBLE_HOLDS_RET: assert property (@(posedge clk) disable iff (rst)
        (slot_bubble && !(op.swrite && op.sreg == SR_RETADDR)) |=> $stable(retaddr)); // R8
    AST_NESTED_RET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (irq_take && op.intret) |=> $stable(retaddr)); // R10
endmodule

// File: tb/irq_sysreg_unit_bench.sv
module irq_sysreg_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HRST = 32'h0000_0010;

    logic        clk = 0;
    logic        rst;
    logic [2:0]  irq_src;
    logic        inst_valid;
    logic [31:0] inst;
    logic [31:0] src_val;
    logic [31:0] next_pc;
    logic        slot_bubble;
    logic [3:0]  irq_id;
    logic        irq_take;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        sr_read_valid;
    logic [3:0]  sr_read_dst;
    logic [31:0] sr_read_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    irq_sysreg_unit #(.HANDLER_RESET(HRST)) u_irq_sysreg_unit (
        .clk(clk), .rst(rst), .irq_src(irq_src), .inst_valid(inst_valid),
        .inst(inst), .src_val(src_val), .next_pc(next_pc), .slot_bubble(slot_bubble),
        .irq_id(irq_id), .irq_take(irq_take), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .sr_read_valid(sr_read_valid),
        .sr_read_dst(sr_read_dst), .sr_read_data(sr_read_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        inst_valid = 0; inst = 0; src_val = 0;
    endtask

    task automatic wr_sr(input logic [3:0] n, input logic [31:0] v);
        inst = {4'hF, 4'h3, n, 4'h6, 16'h0}; inst_valid = 1; src_val = v;
        tick();
        idle();
    endtask

    task automatic rd_sr(input logic [3:0] n, output logic [31:0] v);
        inst = {4'hF, 4'h2, 4'h9, n, 16'h0}; inst_valid = 1;
        #2;
        v = sr_read_data;
        check("R2 read valid", {31'b0, sr_read_valid}, 32'd1);
        check("R2 read dst", {28'b0, sr_read_dst}, 32'd9);
        tick();
        idle();
    endtask

    function automatic logic [3:0] exp_id(input logic [2:0] p);
        if (p[0]) return 4'd1;
        if (p[1]) return 4'd2;
        if (p[2]) return 4'd3;
        return 4'hF;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, exp_ret, exp_cause, hnd;
        irq_src = 0; slot_bubble = 0; next_pc = 0; idle();
        rst = 1;
        repeat (3) tick();
        rst = 0;

        // R1 reset values
        rd_sr(4'd0, v); check("R1 ctl", v, 0);
        rd_sr(4'd1, v); check("R1 handler", v, HRST);
        rd_sr(4'd2, v); check("R1 ret", v, 0);
        rd_sr(4'd3, v); check("R1 cause", v, 0);
        rd_sr(4'd5, v); check("R2 reserved read", v, 0);

        // R3 writes
        hnd = 32'h0000_1000;
        wr_sr(4'd1, hnd);
        wr_sr(4'd2, 32'h2222);
        wr_sr(4'd3, 32'hFFFF_FFFA);
        wr_sr(4'd0, 32'hFFFF_FFFC);
        rd_sr(4'd1, v); check("R3 handler", v, hnd);
        rd_sr(4'd2, v); check("R3 ret", v, 32'h2222);
        rd_sr(4'd3, v); check("R3 cause width", v, 32'hA);
        rd_sr(4'd0, v); check("R3 ctl width", v, 0);
        wr_sr(4'd7, 32'h1234_5678);
        rd_sr(4'd7, v); check("R3 reserved write", v, 0);
        rd_sr(4'd2, v); check("R3 reserved write no alias", v, 32'h2222);
        exp_ret = 32'h2222; exp_cause = 32'hA;

        // R4 sweep with interrupts disabled
        for (int p = 0; p < 8; p++) begin
            irq_src = 3'(p);
            #2;
            check("R4 irq_id", {28'b0, irq_id}, {28'b0, exp_id(3'(p))});
            check("R5 no take when disabled", {31'b0, irq_take}, 0);
            tick();
        end
        irq_src = 0;

        // R5 R6 R8 sweep
        for (int e = 0; e < 2; e++) begin
            for (int b = 0; b < 2; b++) begin
                for (int p = 0; p < 8; p++) begin
                    logic tk;
                    logic [31:0] ectl;
                    wr_sr(4'd0, 32'(e));
                    irq_src = 3'(p); slot_bubble = 1'(b);
                    next_pc = 32'h400 + 32'(p * 16 + b * 4 + e * 256);
                    tk = (e == 1) && (p != 0) && (b == 0);
                    #2;
                    check(b ? "R8 bubble take" : "R5 take", {31'b0, irq_take}, {31'b0, tk});
                    if (tk) begin
                        check("R5 redirect valid", {31'b0, redirect_valid}, 1);
                        check("R5 redirect to handler", redirect_pc, hnd);
                        exp_ret = next_pc; exp_cause = {28'b0, exp_id(3'(p))};
                        ectl = 32'd2;
                    end else ectl = 32'(e);
                    tick();
                    irq_src = 0; slot_bubble = 0;
                    rd_sr(4'd2, v); check("R6 ret saved", v, exp_ret);
                    rd_sr(4'd3, v); check("R6 cause saved", v, exp_cause);
                    rd_sr(4'd0, v); check("R6 enable stack", v, ectl);
                end
            end
        end

        // R7 return from interrupt
        wr_sr(4'd2, 32'h3000);
        wr_sr(4'd0, 32'd2);
        inst = {4'hF, 4'h1, 24'h0}; inst_valid = 1;
        #2;
        check("R7 redirect valid", {31'b0, redirect_valid}, 1);
        check("R7 redirect target", redirect_pc, 32'h3000);
        tick(); idle();
        rd_sr(4'd0, v); check("R7 enable restored", v, 32'd3);

        // R11 malformed / invalid words
        wr_sr(4'd0, 32'd2);
        inst = {4'hF, 4'h1, 24'h1}; inst_valid = 1;
        #2;
        check("R11 bad return no redirect", {31'b0, redirect_valid}, 0);
        tick(); idle();
        rd_sr(4'd0, v); check("R11 bad return no effect", v, 32'd2);
        inst = {4'hE, 4'h3, 4'h1, 4'h0, 16'h0}; inst_valid = 1; src_val = 32'hDEAD;
        #2;
        check("R11 wrong primary no read", {31'b0, sr_read_valid}, 0);
        tick(); idle();
        inst = {4'hF, 4'h3, 4'h1, 4'h0, 16'h0}; inst_valid = 0; src_val = 32'hBEEF;
        tick(); idle();
        inst = {4'hF, 4'h3, 4'h1, 4'h0, 16'h8}; inst_valid = 1; src_val = 32'hCAFE;
        tick(); idle();
        inst = {4'hF, 4'h5, 4'h1, 4'h0, 16'h0}; inst_valid = 1; src_val = 32'hF00D;
        tick(); idle();
        rd_sr(4'd1, v); check("R11 ignored words keep handler", v, hnd);

        // R9 write to control in take cycle
        wr_sr(4'd0, 32'd1);
        irq_src = 3'b100; next_pc = 32'h700;
        inst = {4'hF, 4'h3, 4'h0, 4'h6, 16'h0}; inst_valid = 1; src_val = 32'd0;
        #2;
        check("R9 take uses old enable", {31'b0, irq_take}, 1);
        tick(); idle(); irq_src = 0;
        rd_sr(4'd0, v); check("R9 ctl after conflict", v, 0);
        rd_sr(4'd3, v); check("R9 cause", v, 3);
        wr_sr(4'd0, 32'd0);
        irq_src = 3'b010;
        inst = {4'hF, 4'h3, 4'h0, 4'h6, 16'h0}; inst_valid = 1; src_val = 32'd1;
        #2;
        check("R9 no take on enabling write", {31'b0, irq_take}, 0);
        tick(); idle(); irq_src = 0;
        rd_sr(4'd0, v); check("R9 enable written", v, 1);

        // R10 return and take in one cycle
        wr_sr(4'd2, 32'h5000);
        wr_sr(4'd0, 32'd1);
        irq_src = 3'b010; next_pc = 32'h6000;
        inst = {4'hF, 4'h1, 24'h0}; inst_valid = 1;
        #2;
        check("R10 take", {31'b0, irq_take}, 1);
        check("R10 redirect handler", redirect_pc, hnd);
        tick(); idle(); irq_src = 0;
        rd_sr(4'd2, v); check("R10 ret kept", v, 32'h5000);
        rd_sr(4'd0, v); check("R10 ctl", v, 0);
        rd_sr(4'd3, v); check("R10 cause", v, 2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule